// File: doc/BRIEF.md
# Byte-wide OTP Memory Programming Sequencer

This controller writes a complete image into a parallel, byte-wide, one-time-programmable memory with 18 address bits and 8 data bits. It fetches each target byte from a data source through a request/valid handshake keyed by address. It then drives the memory's chip-select, read-enable and write-strobe lines, its address and its data bus. It also drives two supply-level select outputs that an external regulator turns into real voltages.

For every address the sequencer applies a write pulse and then reads the byte back. While the read-back differs from the target, it repeats the pulse and read-back, up to a hard limit of 25 pulses. A byte that verifies moves the sequencer to the next address. A byte that still differs after the last permitted pulse ends the run as failed. Once the last address has verified, the regulator is moved to a lower level, every byte is fetched again and read back once, and the run ends with pass or with the first mismatching address. A clock-frequency parameter turns every microsecond and nanosecond limit into a cycle count.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, and whenever no run is active, chip-select, read-enable and write-strobe (all active low) are high, the data bus is not driven, `src_req` and `done` are low until a run has finished, and both level selects read 2'b00.
- R2: Each write pulse holds `mem_wr_n` low for exactly round(100 µs × CLK_MHZ) cycles, which lies inside the 95 to 105 µs window. Throughout the pulse `mem_sel_n` is low, `mem_rd_n` is high and the bus is driven.
- R3: Address, data and chip-select are stable and driven for at least ceil(2 µs × CLK_MHZ) cycles before a pulse starts. The data stays driven and unchanged for at least that many cycles after the pulse ends.
- R4: Each read-back lowers `mem_rd_n` and `mem_sel_n` with `mem_wr_n` high and the bus released. The byte is sampled only after ceil(150 ns × CLK_MHZ) cycles. The bus is driven again only after `mem_rd_n` has been high for ceil(130 ns × CLK_MHZ) cycles.
- R5: A mismatching read-back triggers another pulse on the same address. A byte that takes k ≤ 25 pulses to verify receives exactly k pulses, and no address ever receives more than 25.
- R6: Addresses are requested in ascending order from 0 to LAST_ADDR. `src_req` stays high with `src_addr` steady until `src_valid` is seen, and `src_data` is taken in that cycle.
- R7: Both level selects read 2'b01 (programming levels) from the start of a run to the end of the pulse loop, 2'b10 (reduced compare level) for the whole final pass, and 2'b00 once the run has ended.
- R8: After the last address has verified, the sequencer waits ceil(2 µs × CLK_MHZ) cycles at the reduced level. It then re-fetches and reads every address from 0 to LAST_ADDR exactly once, stopping at the first byte that differs from its source byte.
- R9: On failure `done`=1 and `pass`=0, and `fail_addr` holds the failing address. After a pulse-limit failure `fail_pulses`=25 and `fail_data` is the last byte read. After a final-pass mismatch `fail_pulses`=0 and `fail_data` is the mismatching byte read.
- R10: After a clean final pass `done`=1 and `pass`=1. `done` and `pass` hold until `start` is pulsed again, which clears `done` on the next cycle and begins a new run from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a run when idle or finished |
| src_valid | input | 1 | Source byte for `src_addr` is present |
| src_data | input | DATA_W | Source byte |
| mem_d_in | input | DATA_W | Data read from the memory bus |
| src_req | output | 1 | Request for the byte at `src_addr` |
| src_addr | output | ADDR_W | Address of the requested byte |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_d_out | output | DATA_W | Data driven onto the memory bus |
| mem_d_drive | output | 1 | Bus drive enable for `mem_d_out` |
| mem_sel_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read (output) enable, active low |
| mem_wr_n | output | 1 | Write (program) strobe, active low |
| core_lvl | output | 2 | Core supply request: 00 off, 01 program, 10 compare |
| hv_lvl | output | 2 | Program supply request, same encoding |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished without error |
| fail_addr | output | ADDR_W | Address of the failure |
| fail_pulses | output | PCW | Pulses spent on the failing byte, 0 for a compare failure |
| fail_data | output | DATA_W | Byte read at the failure |

## Verification
The properties assume that the source raises `src_valid` only while `src_req` is high, and only for one cycle per request. They also assume that it returns the same byte for an address in both passes, and that `mem_d_in` matters only while the read-enable is low. The bench's source model answers each request half a cycle after it appears and drops `src_valid` once the request is gone. It computes its byte from the address and a per-vector mask, and its memory model drives read data only while selected and read-enabled. `start` is pulsed only while the sequencer is idle or finished.

// File: rtl/otp_seq_pkg.sv
// Shared types and timing conversions for the OTP programming sequencer.
// Assumes an integer clock frequency in MHz.
package otp_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_SETUP, S_PULSE, S_HOLD, S_VERIFY, S_RELEASE,
        S_SETTLE, S_FFETCH, S_FREAD, S_FRELEASE, S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        LVL_OFF   = 2'b00,
        LVL_PROG  = 2'b01,
        LVL_FINAL = 2'b10
    } lvl_e;

    localparam int unsigned T_SETUP_NS  = 2000;
    localparam int unsigned T_HOLD_NS   = 2000;
    localparam int unsigned T_PW_NOM_NS = 100000;
    localparam int unsigned T_PW_MIN_NS = 95000;
    localparam int unsigned T_PW_MAX_NS = 105000;
    localparam int unsigned T_RD_NS     = 150;
    localparam int unsigned T_FLOAT_NS  = 130;

    // Cycles covering at least ns (rounded up, never zero).
    function automatic int unsigned cyc_up(int unsigned ns, int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

    // Cycles nearest to ns (never zero).
    function automatic int unsigned cyc_near(int unsigned ns, int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 500) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

    // Cycles not exceeding ns.
    function automatic int unsigned cyc_down(int unsigned ns, int unsigned mhz);
        return (ns * mhz) / 1000;
    endfunction

endpackage

// File: rtl/otp_seq_timer.sv
// Down-counting phase timer. A load of N makes expired rise in the Nth
// cycle after the load edge. Assumes load_val >= 1.
module otp_seq_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val - TW'(1);
        else if (cnt_q != '0)  cnt_q <= cnt_q - TW'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/otp_pin_decode.sv
// Maps the sequencer state onto memory control pins, bus drive, source
// request and supply-level request. Purely combinational from a register.
module otp_pin_decode
    import otp_seq_pkg::*;
(
    input  seq_state_e st,
    output logic       sel_n,
    output logic       rd_n,
    output logic       wr_n,
    output logic       drive,
    output logic       req,
    output lvl_e       lvl
);
    // One row per state: pin levels for that phase.
    always_comb begin
        sel_n = 1'b1;
        rd_n  = 1'b1;
        wr_n  = 1'b1;
        drive = 1'b0;
        req   = 1'b0;
        lvl   = LVL_OFF;
        unique case (st)
            S_FETCH:   begin lvl = LVL_PROG; req = 1'b1; end
            S_SETUP,
            S_HOLD:    begin lvl = LVL_PROG; sel_n = 1'b0; drive = 1'b1; end
            S_PULSE:   begin lvl = LVL_PROG; sel_n = 1'b0; drive = 1'b1; wr_n = 1'b0; end
            S_VERIFY:  begin lvl = LVL_PROG; sel_n = 1'b0; rd_n = 1'b0; end
            S_RELEASE: begin lvl = LVL_PROG; sel_n = 1'b0; end
            S_SETTLE:  lvl = LVL_FINAL;
            S_FFETCH:  begin lvl = LVL_FINAL; req = 1'b1; end
            S_FREAD:   begin lvl = LVL_FINAL; sel_n = 1'b0; rd_n = 1'b0; end
            S_FRELEASE:begin lvl = LVL_FINAL; sel_n = 1'b0; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/otp_prog_seq.sv
// Programming sequencer: per address, pulse / read-back / retry up to
// MAX_PULSES, then a final compare pass at the reduced supply level.
// Assumes src_valid is a one-cycle answer to src_req and that the source
// returns the same byte for an address in both passes.
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int unsigned          ADDR_W     = 18,
    parameter int unsigned          DATA_W     = 8,
    parameter int unsigned          CLK_MHZ    = 100,
    parameter int unsigned          MAX_PULSES = 25,
    parameter logic [ADDR_W-1:0]    LAST_ADDR  = '1,
    parameter int unsigned          PCW        = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic [DATA_W-1:0] mem_d_in,
    output logic              src_req,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_d_out,
    output logic              mem_d_drive,
    output logic              mem_sel_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [1:0]        core_lvl,
    output logic [1:0]        hv_lvl,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [PCW-1:0]    fail_pulses,
    output logic [DATA_W-1:0] fail_data
);
    localparam int unsigned SETUP_CYC = cyc_up(T_SETUP_NS, CLK_MHZ);
    localparam int unsigned HOLD_CYC  = cyc_up(T_HOLD_NS, CLK_MHZ);
    localparam int unsigned PW_CYC    = cyc_near(T_PW_NOM_NS, CLK_MHZ);
    localparam int unsigned RD_CYC    = cyc_up(T_RD_NS, CLK_MHZ);
    localparam int unsigned FLT_CYC   = cyc_up(T_FLOAT_NS, CLK_MHZ);
    localparam int unsigned TW        = $clog2(PW_CYC + 1);

    seq_state_e        st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q, rd_q;
    logic [PCW-1:0]    pulses_q;
    logic              tmr_exp;
    logic [TW-1:0]     tmr_val;
    lvl_e              lvl;

    logic is_last, match_q, rd_match, at_cap, launch;
    assign is_last  = (addr_q == LAST_ADDR);
    assign match_q  = (rd_q == data_q);
    assign rd_match = (mem_d_in == data_q);
    assign at_cap   = (pulses_q == PCW'(MAX_PULSES));
    assign launch   = start && (st_q == S_IDLE || st_q == S_DONE);

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE, S_DONE: if (launch) st_d = S_FETCH;
            S_FETCH:    if (src_valid) st_d = S_SETUP;
            S_SETUP:    if (tmr_exp) st_d = S_PULSE;
            S_PULSE:    if (tmr_exp) st_d = S_HOLD;
            S_HOLD:     if (tmr_exp) st_d = S_VERIFY;
            S_VERIFY:   if (tmr_exp) st_d = S_RELEASE;
            S_RELEASE:  if (tmr_exp) begin
                            if (match_q)     st_d = is_last ? S_SETTLE : S_FETCH;
                            else if (at_cap) st_d = S_DONE;
                            else             st_d = S_SETUP;
                        end
            S_SETTLE:   if (tmr_exp) st_d = S_FFETCH;
            S_FFETCH:   if (src_valid) st_d = S_FREAD;
            S_FREAD:    if (tmr_exp) st_d = rd_match ? S_FRELEASE : S_DONE;
            S_FRELEASE: if (tmr_exp) st_d = is_last ? S_DONE : S_FFETCH;
            default:    st_d = S_IDLE;
        endcase
    end

    // Duration of the phase being entered.
    always_comb begin
        unique case (st_d)
            S_SETUP, S_SETTLE:     tmr_val = TW'(SETUP_CYC);
            S_PULSE:               tmr_val = TW'(PW_CYC);
            S_HOLD:                tmr_val = TW'(HOLD_CYC);
            S_VERIFY, S_FREAD:     tmr_val = TW'(RD_CYC);
            S_RELEASE, S_FRELEASE: tmr_val = TW'(FLT_CYC);
            default:               tmr_val = TW'(1);
        endcase
    end

    otp_seq_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st_d != st_q),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Address, byte, pulse count and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0; data_q <= '0; rd_q <= '0; pulses_q <= '0;
            done <= 1'b0; pass <= 1'b0;
            fail_addr <= '0; fail_pulses <= '0; fail_data <= '0;
        end else begin
            unique case (st_q)
                S_IDLE, S_DONE: if (launch) begin
                    addr_q <= '0; pulses_q <= '0;
                    done <= 1'b0; pass <= 1'b0;
                    fail_addr <= '0; fail_pulses <= '0; fail_data <= '0;
                end
                S_FETCH: if (src_valid) begin
                    data_q   <= src_data;
                    pulses_q <= '0;
                end
                S_SETUP:  if (tmr_exp) pulses_q <= pulses_q + PCW'(1);
                S_VERIFY: if (tmr_exp) rd_q <= mem_d_in;
                S_RELEASE: if (tmr_exp) begin
                    if (match_q) addr_q <= is_last ? '0 : addr_q + ADDR_W'(1);
                    else if (at_cap) begin
                        done <= 1'b1; pass <= 1'b0;
                        fail_addr <= addr_q; fail_pulses <= pulses_q; fail_data <= rd_q;
                    end
                end
                S_FFETCH: if (src_valid) data_q <= src_data;
                S_FREAD: if (tmr_exp && !rd_match) begin
                    done <= 1'b1; pass <= 1'b0;
                    fail_addr <= addr_q; fail_pulses <= '0; fail_data <= mem_d_in;
                end
                S_FRELEASE: if (tmr_exp) begin
                    if (is_last) begin done <= 1'b1; pass <= 1'b1; end
                    else addr_q <= addr_q + ADDR_W'(1);
                end
                default: ;
            endcase
        end
    end

    otp_pin_decode u_pins (
        .st    (st_q),
        .sel_n (mem_sel_n),
        .rd_n  (mem_rd_n),
        .wr_n  (mem_wr_n),
        .drive (mem_d_drive),
        .req   (src_req),
        .lvl   (lvl)
    );

    assign core_lvl  = lvl;
    assign hv_lvl    = lvl;
    assign src_addr  = addr_q;
    assign mem_addr  = addr_q;
    assign mem_d_out = data_q;
endmodule

// File: rtl/otp_seq_checker.sv
// Timing and pin-relation properties for otp_prog_seq, observed at its
// ports. Windows that scale with CLK_MHZ are measured with counters.
module otp_seq_checker
    import otp_seq_pkg::*;
#(
    parameter int unsigned CLK_MHZ    = 100,
    parameter int unsigned MAX_PULSES = 25
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_sel_n,
    input logic       mem_rd_n,
    input logic       mem_wr_n,
    input logic       mem_d_drive,
    input logic [1:0] core_lvl,
    input logic       done,
    input logic       src_req,
    input logic       src_valid
);
    localparam int unsigned SETUP_CYC = cyc_up(T_SETUP_NS, CLK_MHZ);
    localparam int unsigned HOLD_CYC  = cyc_up(T_HOLD_NS, CLK_MHZ);
    localparam int unsigned PW_MIN    = cyc_up(T_PW_MIN_NS, CLK_MHZ);
    localparam int unsigned PW_MAX    = cyc_down(T_PW_MAX_NS, CLK_MHZ);
    localparam int unsigned FLT_CYC   = cyc_up(T_FLOAT_NS, CLK_MHZ);
    localparam int unsigned SAT       = 1 << 24;

    int unsigned low_cnt, su_cnt, ho_cnt, rdh_cnt, pc_cnt;

    // Run-length counters for strobe low, setup, hold and read-enable high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= 0; su_cnt <= 0; ho_cnt <= 0; rdh_cnt <= SAT; pc_cnt <= 0;
        end else begin
            low_cnt <= !mem_wr_n ? ((low_cnt < SAT) ? low_cnt + 1 : low_cnt) : 0;
            su_cnt  <= (mem_d_drive && !mem_sel_n) ? ((su_cnt < SAT) ? su_cnt + 1 : su_cnt) : 0;
            ho_cnt  <= !mem_wr_n ? 0 : (mem_d_drive ? ((ho_cnt < SAT) ? ho_cnt + 1 : ho_cnt) : ho_cnt);
            rdh_cnt <= mem_rd_n ? ((rdh_cnt < SAT) ? rdh_cnt + 1 : rdh_cnt) : 0;
            if (src_req && src_valid)            pc_cnt <= 0;
            else if (mem_wr_n == 1'b0 && low_cnt == 0) pc_cnt <= pc_cnt + 1;
        end
    end

    assert_pulse_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (low_cnt >= PW_MIN && low_cnt <= PW_MAX));
    assert_pulse_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (!mem_sel_n && mem_rd_n && mem_d_drive));
    assert_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> su_cnt >= SETUP_CYC);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_d_drive) |-> ho_cnt >= HOLD_CYC);
    assert_read_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (!mem_sel_n && mem_wr_n && !mem_d_drive));
    assert_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_d_drive) |-> rdh_cnt >= FLT_CYC);
    assert_retry_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_cnt <= MAX_PULSES);
    assert_lvl_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> core_lvl == LVL_PROG);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_sel_n && mem_rd_n && mem_wr_n && !mem_d_drive
                  && core_lvl == LVL_OFF && !src_req));
endmodule

bind otp_prog_seq otp_seq_checker #(
    .CLK_MHZ    (CLK_MHZ),
    .MAX_PULSES (MAX_PULSES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_sel_n   (mem_sel_n),
    .mem_rd_n    (mem_rd_n),
    .mem_wr_n    (mem_wr_n),
    .mem_d_drive (mem_d_drive),
    .core_lvl    (core_lvl),
    .done        (done),
    .src_req     (src_req),
    .src_valid   (src_valid)
);

// File: tb/tb_otp_prog_seq.sv
// Bench: vector table of memory behaviours walked by one loop, then
// directed checks for idle holding and reset during a run.
module tb_otp_prog_seq;
    localparam int unsigned AW = 18;
    localparam int unsigned DW = 8;
    localparam int unsigned MHZ = 1;
    localparam int unsigned LAST = 7;
    localparam int unsigned NBYTES = LAST + 1;
    localparam int unsigned PW_EXP = 100;   // round(100 us * 1 MHz)
    localparam int unsigned SU_EXP = 2;     // ceil(2 us * 1 MHz)

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic src_valid = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic [DW-1:0] mem_d_in;
    logic src_req, mem_d_drive, mem_sel_n, mem_rd_n, mem_wr_n, done, pass;
    logic [AW-1:0] src_addr, mem_addr, fail_addr;
    logic [DW-1:0] mem_d_out, fail_data;
    logic [1:0] core_lvl, hv_lvl;
    logic [4:0] fail_pulses;

    always #5 clk = ~clk;

    otp_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(MHZ), .MAX_PULSES(25),
                   .LAST_ADDR(AW'(LAST))) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_valid(src_valid),
        .src_data(src_data), .mem_d_in(mem_d_in), .src_req(src_req),
        .src_addr(src_addr), .mem_addr(mem_addr), .mem_d_out(mem_d_out),
        .mem_d_drive(mem_d_drive), .mem_sel_n(mem_sel_n), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .core_lvl(core_lvl), .hv_lvl(hv_lvl), .done(done),
        .pass(pass), .fail_addr(fail_addr), .fail_pulses(fail_pulses),
        .fail_data(fail_data));

    typedef struct packed {
        logic [4:0] base_need;
        logic [2:0] sp_addr;
        logic [4:0] sp_need;
        logic       weak_en;
        logic [2:0] weak_addr;
        logic [7:0] dxor;
        logic       exp_pass;
        logic [2:0] exp_addr;
        logic [4:0] exp_pulses;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{5'd1, 3'd3, 5'd1,  1'b0, 3'd0, 8'h00, 1'b1, 3'd0, 5'd0},
        '{5'd2, 3'd6, 5'd25, 1'b0, 3'd0, 8'h5A, 1'b1, 3'd0, 5'd0},
        '{5'd1, 3'd4, 5'd26, 1'b0, 3'd0, 8'h00, 1'b0, 3'd4, 5'd25},
        '{5'd3, 3'd0, 5'd7,  1'b1, 3'd5, 8'hA5, 1'b0, 3'd5, 5'd0},
        '{5'd1, 3'd0, 5'd25, 1'b0, 3'd0, 8'h5A, 1'b1, 3'd0, 5'd0},
        '{5'd1, 3'd7, 5'd26, 1'b0, 3'd0, 8'hA5, 1'b0, 3'd7, 5'd25}
    };

    int nchk = 0, nfail = 0;

    // Memory and source model state.
    logic [7:0] mem [NBYTES];
    int pcnt [NBYTES];
    int need [NBYTES];
    logic [7:0] cur_xor = '0;
    logic weak_en = 1'b0;
    logic [2:0] weak_addr = '0;

    function automatic logic [7:0] pat(input int a, input logic [7:0] x);
        return 8'(a * 29 + 60) ^ x;
    endfunction

    assign mem_d_in = (!mem_rd_n && !mem_sel_n)
        ? (mem[mem_addr[2:0]] ^ ((weak_en && core_lvl == 2'b10 && mem_addr[2:0] == weak_addr) ? 8'h01 : 8'h00))
        : 8'h00;

    // Monitor counters.
    int v2, v3, v4, v7, hs_err, fr_cnt, hs_next, low_run, su_run, ho_run;
    logic pw_prev = 1'b1, rd_prev = 1'b1, dr_prev = 1'b0;
    logic [AW-1:0] a_prev = '0;
    logic [DW-1:0] d_prev = '0;

    // Source answers, memory programming and protocol monitors, at negedge.
    always @(negedge clk) begin
        if (src_req && !src_valid) begin
            if (int'(src_addr) != hs_next) hs_err++;
            hs_next = (hs_next == LAST) ? 0 : hs_next + 1;
        end
        src_data  = pat(int'(src_addr), cur_xor);
        src_valid = src_req && !src_valid;

        if (!mem_wr_n) begin
            low_run++;
            if (mem_sel_n || !mem_rd_n || !mem_d_drive) v2++;
            if (core_lvl != 2'b01) v7++;
        end
        if (pw_prev && !mem_wr_n && su_run < SU_EXP) v3++;
        if (!pw_prev && mem_wr_n) begin
            if (low_run != PW_EXP) v2++;
            low_run = 0;
            pcnt[mem_addr[2:0]]++;
            if (pcnt[mem_addr[2:0]] >= need[mem_addr[2:0]])
                mem[mem_addr[2:0]] = mem[mem_addr[2:0]] & mem_d_out;
        end
        if (dr_prev && !mem_d_drive && ho_run < SU_EXP) v3++;
        if (mem_wr_n) begin
            if (mem_d_drive && !mem_sel_n)
                su_run = (mem_addr == a_prev && mem_d_out == d_prev) ? su_run + 1 : 1;
            else su_run = 0;
            if (mem_d_drive && mem_d_out == d_prev) ho_run++;
        end else ho_run = 0;
        if (!mem_rd_n && (mem_d_drive || !mem_wr_n || mem_sel_n)) v4++;
        if (rd_prev && !mem_rd_n && core_lvl == 2'b10) fr_cnt++;
        if (core_lvl != hv_lvl) v7++;
        pw_prev = mem_wr_n; rd_prev = mem_rd_n; dr_prev = mem_d_drive;
        a_prev = mem_addr; d_prev = mem_d_out;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_pins(input string req);
        chk(mem_sel_n && mem_rd_n && mem_wr_n && !mem_d_drive && !src_req,
            req, {mem_sel_n, mem_rd_n, mem_wr_n, mem_d_drive, src_req}, 5'b11100);
        chk(core_lvl == 2'b00 && hv_lvl == 2'b00, req, {core_lvl, hv_lvl}, 0);
    endtask

    task automatic run_vec(input vec_t v);
        int cyc;
        int mism;
        int exp_fr;
        cur_xor = v.dxor; weak_en = v.weak_en; weak_addr = v.weak_addr;
        for (int a = 0; a < NBYTES; a++) begin
            mem[a] = 8'hFF; pcnt[a] = 0;
            need[a] = (a == int'(v.sp_addr)) ? int'(v.sp_need) : int'(v.base_need);
        end
        v2 = 0; v3 = 0; v4 = 0; v7 = 0; hs_err = 0; fr_cnt = 0; hs_next = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R10 start clears done", done, 0);
        cyc = 0;
        while (!done && cyc < 30000) begin @(negedge clk); cyc++; end
        chk(done, "R10 run completes (watchdog)", done, 1);
        chk(pass == v.exp_pass, "R10 pass flag", pass, v.exp_pass);
        if (!v.exp_pass) begin
            chk(fail_addr == AW'(v.exp_addr), "R9 fail_addr", fail_addr, v.exp_addr);
            chk(fail_pulses == v.exp_pulses, "R9 fail_pulses", fail_pulses, v.exp_pulses);
            if (v.exp_pulses != 0)
                chk(fail_data == 8'hFF, "R9 fail_data after pulse limit", fail_data, 8'hFF);
            else
                chk(fail_data == (pat(int'(v.weak_addr), v.dxor) ^ 8'h01),
                    "R9 fail_data after compare", fail_data, pat(int'(v.weak_addr), v.dxor) ^ 8'h01);
        end
        mism = 0;
        for (int a = 0; a < NBYTES; a++) begin
            int e;
            e = need[a];
            if (!v.exp_pass && v.exp_pulses != 0) begin
                if (a == int'(v.exp_addr)) e = 25;
                else if (a > int'(v.exp_addr)) e = 0;
            end
            if (pcnt[a] != e) mism++;
        end
        chk(mism == 0, "R5 pulses per address", mism, 0);
        chk(hs_err == 0, "R6 request order", hs_err, 0);
        exp_fr = v.exp_pass ? NBYTES : ((v.exp_pulses != 0) ? 0 : int'(v.weak_addr) + 1);
        chk(fr_cnt == exp_fr, "R8 final-pass reads", fr_cnt, exp_fr);
        chk(v2 == 0, "R2 pulse width and pins", v2, 0);
        chk(v3 == 0, "R3 setup and hold", v3, 0);
        chk(v4 == 0, "R4 read-back pins", v4, 0);
        chk(v7 == 0, "R7 level select in pulses", v7, 0);
        repeat (5) @(negedge clk);
        chk(done && pass == v.exp_pass, "R10 result held", {done, pass}, {1'b1, v.exp_pass});
        idle_pins("R1 R7 idle after run");
    endtask

    initial begin
        for (int a = 0; a < NBYTES; a++) begin mem[a] = 8'hFF; pcnt[a] = 0; need[a] = 1; end
        v2 = 0; v3 = 0; v4 = 0; v7 = 0; hs_err = 0; fr_cnt = 0; hs_next = 0;
        low_run = 0; su_run = 0; ho_run = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_pins("R1 reset state");
        chk(!done && !pass, "R1 reset flags", {done, pass}, 0);
        for (int i = 0; i < 6; i++) run_vec(VECS[i]);
        // Directed: reset in the middle of a pulse loop.
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        idle_pins("R1 reset during run");
        chk(!done, "R1 done after reset", done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        idle_pins("R1 idle after release");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Global watchdog: a hung run counts as a miscompare.
    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule